// File: doc/BRIEF.md
# Serial Receive Status Flag Controller

This block sits between the receive shift register of a serial port and the CPU. For every completed frame it decides whether the frame goes into the receive data register. It also keeps two status flags up to date. The first is a "data waiting" flag. The second is an overrun flag, which records that a good frame arrived while earlier data was still unread.

The CPU sees a two-bit status register and the data register. Both are read combinationally, and reads and writes are single-cycle strobes. A flag clears only when the CPU first reads it as one and then writes zero to it. Reading the data register also empties the data-waiting flag. While an overrun is pending, the register is frozen and later frames are dropped. A halt signal goes out to the receiver. In synchronous mode a transmit-inhibit signal also goes out.

Top module: `rx_status_ctrl`

## Requirements
- R1: A frame strobe with rx_en=1, frame_err=0, overrun clear and the full flag clear loads frame_data into data_q and sets full_flag, both visible in the next cycle.
- R2: A data_rd strobe clears full_flag in the next cycle, unless a frame is loaded in that same cycle.
- R3: A status write clears a flag only when its write bit is 0 and a status read since the previous status write returned 1 for that flag. Every status write consumes the arm of both flags. Writing 1 never sets or keeps a flag by itself.
- R4: A good frame that arrives while the full flag is 1 sets ovr_flag in the next cycle and is discarded, so data_q keeps its earlier value.
- R5: A frame strobe with frame_err=1 changes neither data_q, full_flag nor ovr_flag.
- R6: A frame strobe with rx_en=0 changes neither data_q, full_flag nor ovr_flag.
- R7: While ovr_flag is 1, frame strobes are ignored and rx_halt is 1. tx_inhibit is 1 exactly when ovr_flag is 1 and sync_mode is 1.
- R8: ovr_flag is not cleared by data_rd. It is cleared only by the read-as-one then write-zero sequence of R3.
- R9: After reset, both flags, data_q, rx_halt and tx_inhibit are 0.
- R10: When a clearing action and a frame strobe fall in the same cycle, the clearing takes effect first. The frame is then judged against the cleared flags. So data_rd together with a good frame while full loads the new frame and raises no overrun.
- R11: stat_rdata returns the current flags combinationally, with bit 1 = full and bit 0 = overrun. A flag's arm is dropped whenever that flag is cleared, so a later setting of the flag needs a fresh read before a zero-write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_done | input | 1 | One-cycle strobe: a frame has been shifted in |
| frame_data | input | DATA_W | Data of the completed frame |
| frame_err | input | 1 | The completed frame has a reception error |
| rx_en | input | 1 | Receive enable |
| sync_mode | input | 1 | 1 = synchronous mode |
| stat_rd | input | 1 | CPU read strobe, status register |
| stat_wr | input | 1 | CPU write strobe, status register |
| stat_wdata | input | 2 | Status write data (bit 1 full, bit 0 overrun) |
| data_rd | input | 1 | CPU read strobe, data register |
| stat_rdata | output | 2 | Status read value (bit 1 full, bit 0 overrun) |
| data_q | output | DATA_W | Receive data register |
| full_flag | output | 1 | Receive data waiting |
| ovr_flag | output | 1 | Overrun pending |
| rx_halt | output | 1 | Reception halted by overrun |
| tx_inhibit | output | 1 | Transmission halted (overrun in synchronous mode) |

## Verification
The assertions check on every cycle the local rules:
- a loaded frame lands in the register and sets the full flag;
- errored or disabled frames produce no event;
- a pending overrun blocks frame events;
- the overrun flag is sticky outside status writes;
- the data register holds whenever nothing is loaded.

The read-then-write-zero protocol can only be shown by the bench's sequences. So can the consumption of arms by writes, the loss of an arm when a flag is cleared, and same-cycle ordering. A long mixed-input sweep compares every output against a bench model each cycle.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int ST_W        = 2;
  localparam int ST_FULL_BIT = 1;
  localparam int ST_OVR_BIT  = 0;

  typedef enum logic [2:0] {
    V_NONE     = 3'd0,
    V_LOAD     = 3'd1,
    V_OVERRUN  = 3'd2,
    V_DROP_ERR = 3'd3,
    V_DROP_OFF = 3'd4,
    V_DROP_HLT = 3'd5
  } verdict_e;

  // Decide the fate of a frame against flags already cleared this cycle.
  function automatic verdict_e judge_frame(input logic done, input logic en,
                                           input logic err, input logic full_mid,
                                           input logic ovr_mid);
    verdict_e v;
    if (!done)        v = V_NONE;
    else if (!en)     v = V_DROP_OFF;
    else if (err)     v = V_DROP_ERR;
    else if (ovr_mid) v = V_DROP_HLT;
    else if (full_mid) v = V_OVERRUN;
    else              v = V_LOAD;
    return v;
  endfunction

  function automatic logic [ST_W-1:0] pack_status(input logic full, input logic ovr);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_FULL_BIT] = full;
    s[ST_OVR_BIT]  = ovr;
    return s;
  endfunction

endpackage

// File: rtl/rxs_flag_cell.sv
module rxs_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic hw_clr_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic arm_o,
  output logic clr_o
);
  logic flag_q, arm_q;
  logic flag_d, arm_d;

  assign clr_o = hw_clr_i | (wr_i & ~wbit_i & arm_q);

  always_comb begin
    flag_d = (flag_q & ~clr_o) | set_i;
    if (wr_i) arm_d = 1'b0;
    else      arm_d = (arm_q | (rd_i & flag_q)) & ~clr_o;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/rxs_data_reg.sv
module rxs_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_err,
  input  logic              rx_en,
  input  logic              sync_mode,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [1:0]        stat_wdata,
  input  logic              data_rd,
  output logic [1:0]        stat_rdata,
  output logic [DATA_W-1:0] data_q,
  output logic              full_flag,
  output logic              ovr_flag,
  output logic              rx_halt,
  output logic              tx_inhibit
);
  import rxs_pkg::*;

  localparam int NFLAG = ST_W;

  logic [NFLAG-1:0] set_vec, hwclr_vec, flag_vec, arm_vec, clr_vec;

  // named internal events
  logic     clr_full, clr_ovr, full_mid, ovr_mid, load_evt, ovr_evt;
  verdict_e verdict;

  assign hwclr_vec[ST_FULL_BIT] = data_rd;
  assign hwclr_vec[ST_OVR_BIT]  = 1'b0;
  assign set_vec[ST_FULL_BIT]   = load_evt;
  assign set_vec[ST_OVR_BIT]    = ovr_evt;

  generate
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      rxs_flag_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_vec[g]),
        .hw_clr_i (hwclr_vec[g]),
        .rd_i     (stat_rd),
        .wr_i     (stat_wr),
        .wbit_i   (stat_wdata[g]),
        .flag_o   (flag_vec[g]),
        .arm_o    (arm_vec[g]),
        .clr_o    (clr_vec[g])
      );
    end
  endgenerate

  assign full_flag = flag_vec[ST_FULL_BIT];
  assign ovr_flag  = flag_vec[ST_OVR_BIT];
  assign clr_full  = clr_vec[ST_FULL_BIT];
  assign clr_ovr   = clr_vec[ST_OVR_BIT];
  assign full_mid  = full_flag & ~clr_full;
  assign ovr_mid   = ovr_flag & ~clr_ovr;

  assign verdict  = judge_frame(frame_done, rx_en, frame_err, full_mid, ovr_mid);
  assign load_evt = (verdict == V_LOAD);
  assign ovr_evt  = (verdict == V_OVERRUN);

  rxs_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_evt),
    .d_i    (frame_data),
    .q_o    (data_q)
  );

  assign stat_rdata = pack_status(full_flag, ovr_flag);
  assign rx_halt    = ovr_flag;
  assign tx_inhibit = ovr_flag & sync_mode;

  logic unused_arm;
  assign unused_arm = ^arm_vec;
endmodule

// File: rtl/rx_status_ctrl_chk.sv
module rx_status_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              frame_err,
  input logic              rx_en,
  input logic              data_rd,
  input logic              stat_wr,
  input logic [DATA_W-1:0] frame_data,
  input logic [DATA_W-1:0] data_q,
  input logic              full_flag,
  input logic              ovr_flag,
  input logic              rx_halt,
  input logic              tx_inhibit,
  input logic              load_evt,
  input logic              ovr_evt,
  input logic              clr_full,
  input logic              clr_ovr
);
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> full_flag && (data_q == $past(frame_data)));

  p_rd_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !load_evt) |=> !full_flag);

  p_overrun_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_flag && $stable(data_q));

  p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(data_q));

  p_err_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_err) |-> !load_evt && !ovr_evt);

  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !load_evt && !ovr_evt);

  p_halt_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !clr_ovr) |-> !load_evt && !ovr_evt);

  p_txinh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_inhibit |-> rx_halt);

  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !stat_wr) |=> ovr_flag);

  p_clear_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && clr_full && !ovr_flag && frame_done && rx_en && !frame_err) |-> load_evt);
endmodule

bind rx_status_ctrl rx_status_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_err(frame_err),
  .rx_en(rx_en), .data_rd(data_rd), .stat_wr(stat_wr), .frame_data(frame_data),
  .data_q(data_q), .full_flag(full_flag), .ovr_flag(ovr_flag), .rx_halt(rx_halt),
  .tx_inhibit(tx_inhibit), .load_evt(load_evt), .ovr_evt(ovr_evt),
  .clr_full(clr_full), .clr_ovr(clr_ovr)
);

// File: tb/tb_rx_status_ctrl.sv
`timescale 1ns/1ps
module tb_rx_status_ctrl;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_done = 0, frame_err = 0, rx_en = 1, sync_mode = 0;
  logic stat_rd = 0, stat_wr = 0, data_rd = 0;
  logic [1:0] stat_wdata = 2'b11;
  logic [DW-1:0] frame_data = '0;
  logic [1:0] stat_rdata;
  logic [DW-1:0] data_q;
  logic full_flag, ovr_flag, rx_halt, tx_inhibit;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_status_ctrl #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .frame_err(frame_err), .rx_en(rx_en), .sync_mode(sync_mode),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .data_rd(data_rd), .stat_rdata(stat_rdata), .data_q(data_q),
    .full_flag(full_flag), .ovr_flag(ovr_flag), .rx_halt(rx_halt),
    .tx_inhibit(tx_inhibit)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    frame_done = 0; frame_err = 0; stat_rd = 0; stat_wr = 0; data_rd = 0;
    stat_wdata = 2'b11;
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic frame(input logic [DW-1:0] d);
    frame_done = 1; frame_data = d; cyc();
  endtask

  task automatic sread();  stat_rd = 1; cyc(); endtask
  task automatic swrite(input logic [1:0] w); stat_wr = 1; stat_wdata = w; cyc(); endtask

  // bench model state
  logic m_full, m_ovr, m_af, m_ao;
  logic [DW-1:0] m_data;

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk("R9 flags", {30'd0, stat_rdata}, 0);
    chk("R9 data", data_q, 0);
    chk("R9 halt", {rx_halt, tx_inhibit}, 0);
    rst_n = 1;
    cyc();

    frame(8'hA5);
    chk("R1 full", full_flag, 1);
    chk("R1 data", data_q, 8'hA5);
    chk("R11 status bits", stat_rdata, 2'b10);

    swrite(2'b00);
    chk("R3 write0 without read", full_flag, 1);
    sread(); swrite(2'b10);
    chk("R3 write1 no clear", full_flag, 1);
    swrite(2'b00);
    chk("R3 arm consumed", full_flag, 1);
    sread(); swrite(2'b00);
    chk("R3 read-then-write0 clears", full_flag, 0);

    frame(8'h3C);
    frame(8'h77);
    chk("R4 overrun set", ovr_flag, 1);
    chk("R4 data kept", data_q, 8'h3C);
    chk("R7 halt", rx_halt, 1);
    chk("R7 no inhibit async", tx_inhibit, 0);
    sync_mode = 1; #1;
    chk("R7 inhibit sync", tx_inhibit, 1);
    sync_mode = 0;

    data_rd = 1; cyc();
    chk("R2 data read clears", full_flag, 0);
    chk("R8 data read keeps ovr", ovr_flag, 1);
    frame(8'h11);
    chk("R7 frame ignored full", full_flag, 0);
    chk("R7 frame ignored data", data_q, 8'h3C);

    sread(); swrite(2'b11);
    chk("R8 write1 keeps ovr", ovr_flag, 1);
    sread(); swrite(2'b10);
    chk("R8 clear ovr", ovr_flag, 0);
    chk("R7 halt released", rx_halt, 0);

    frame_err = 1; frame(8'h99);
    chk("R5 err full", full_flag, 0);
    chk("R5 err data", data_q, 8'h3C);
    rx_en = 0; frame(8'h55);
    chk("R6 disabled full", full_flag, 0);
    chk("R6 disabled data", data_q, 8'h3C);
    rx_en = 1;

    frame(8'h42);
    data_rd = 1; frame(8'h24);
    chk("R10 full", full_flag, 1);
    chk("R10 data", data_q, 8'h24);
    chk("R10 no overrun", ovr_flag, 0);

    stat_rd = 1; data_rd = 1; cyc();
    chk("R2 cleared", full_flag, 0);
    frame(8'h66);
    swrite(2'b00);
    chk("R11 arm lost on clear", full_flag, 1);

    // sweep against model
    m_full = 1; m_ovr = 0; m_af = 0; m_ao = 0; m_data = 8'h66;
    begin
      logic [15:0] r;
      r = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
        logic wf, wo, cf, om, fm, good;
        r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
        frame_done = r[0]; frame_err = r[1] & r[2]; rx_en = ~(r[3] & r[4]);
        data_rd = r[5] & r[6]; stat_rd = r[7]; stat_wr = r[8] & r[9];
        stat_wdata = r[11:10]; sync_mode = r[12]; frame_data = r[15:8] ^ i[7:0];
        wf = stat_wr && !stat_wdata[1] && m_af;
        wo = stat_wr && !stat_wdata[0] && m_ao;
        cf = data_rd || wf;
        fm = m_full && !cf;
        om = m_ovr && !wo;
        good = frame_done && rx_en && !frame_err && !om;
        m_af = stat_wr ? 1'b0 : ((m_af || (stat_rd && m_full)) && !cf);
        m_ao = stat_wr ? 1'b0 : ((m_ao || (stat_rd && m_ovr)) && !wo);
        if (good && !fm) m_data = frame_data;
        m_ovr = om || (good && fm);
        m_full = fm || good;
        @(posedge clk); #1;
        chk("R1 R3 R4 sweep status", stat_rdata, {m_full, m_ovr});
        chk("R1 R4 R5 R6 sweep data", data_q, m_data);
        chk("R7 sweep inhibit", {rx_halt, tx_inhibit}, {m_ovr, m_ovr & sync_mode});
      end
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule